// File: doc/BRIEF.md
# Floating-Bus Attribute Readback Port

This block sets the value that a retro home-computer bus returns when the CPU reads an I/O port that no peripheral owns. The display controller fetches one attribute byte at a time and marks each fetch with a load strobe. It also raises a flag for the span of each line in which attributes are fetched. The block keeps the most recently strobed attribute in an 8-bit holding register. During a CPU I/O read of any unowned port, it drives that byte onto the data bus, but only while the fetch window flag is high. At all other times the bus is left undriven and reads as all ones, standing in for the pull-up resistors on a real board. A program that polls an unused port therefore sees attribute bytes alternating with 0xFF, in step with the raster.

A small state machine classifies each bus cycle from the active-low CPU strobes and a vector of decoded port hits, one bit per owned port. It has five states. IDLE means no I/O request. OPEN_RD is a read of an unowned port. CLAIMED is an access that an owned port decodes. WRITE is an I/O write. ACK is an interrupt acknowledge. The transitions are as follows. Release goes to IDLE whenever the I/O request is high. Acknowledge entry goes from IDLE or OPEN_RD to ACK when the I/O request and M1 are both low. Claim entry goes from IDLE or OPEN_RD to CLAIMED when any port hit is high. Open-read entry goes from IDLE to OPEN_RD on a read with M1 high and no hit. Write entry goes from IDLE or OPEN_RD to WRITE when read is high. ACK, CLAIMED and WRITE hold until the release. This way, a strobe that changes in the middle of a cycle can never turn the bus driver on. The model of the external bus is the data output while the enable is high, and 0xFF otherwise.

Top module: `fbus_attr_port`

## Requirements
- R1: While reset is low, and in the first cycle after it, the drive enable is 0 and the modelled bus reads 0xFF. The holding register resets to 0xFF.
- R2: The holding register loads the attribute byte at a clock edge where the load strobe is high. Otherwise it keeps its value, whatever the attribute input does.
- R3: In the cycle after a clock edge that samples I/O request low, read low, M1 high and no port hit, the state is OPEN_RD. If the fetch window is high, the drive enable is 1 and the modelled bus carries the held byte. No address is involved: every unowned port answers.
- R4: Outside the fetch window the drive enable is 0 and the modelled bus reads 0xFF, even in OPEN_RD.
- R5: When I/O request and M1 are both sampled low, the state becomes ACK and nothing is driven. ACK holds while I/O request stays low, even if M1 or read change.
- R6: When any port-hit bit is sampled high during an I/O request, the state becomes CLAIMED and nothing is driven. CLAIMED holds until the I/O request is released, even if the hit drops.
- R7: An I/O request sampled with read high (a write) leads to WRITE. Nothing is driven, and WRITE holds until release.
- R8: Whenever the drive enable is 0, the data output is 0xFF and the modelled bus reads 0xFF.
- R9: A clock edge that samples the I/O request high returns the state to IDLE, with the drive enable at 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attr_byte | input | 8 | Attribute byte fetched by the display controller |
| attr_stb | input | 1 | Load strobe for the fetched attribute |
| attr_window | input | 1 | High while the raster is in the attribute-fetch span |
| iorq_n | input | 1 | CPU I/O request, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| m1_n | input | 1 | CPU opcode-fetch/acknowledge marker, active low |
| port_hit | input | N_PORTS (4) | One bit per owned port, high when that port decodes the access |
| bus_drive | output | 1 | High while the block drives the data bus |
| bus_data | output | 8 | Byte driven while enabled, 0xFF otherwise |
| bus_view | output | 8 | Modelled bus value: bus_data when driven, 0xFF otherwise |

## Verification
The hardest situations to reach are cycles that begin as one kind and change part way through. Examples are an acknowledge whose M1 rises while the I/O request is still low, or a claimed access whose port hit drops, both arriving while the fetch window is open and a fresh attribute is held. Directed sequences build each of these with the window forced high. Seeded random bus cycles then run against a free-running raster, with M1 and port-hit flips injected inside held cycles. This sweeps every state against both window phases. A bench reference model predicts the state, the held byte and the bus value every cycle.

// File: rtl/fbus_pkg.sv
package fbus_pkg;
    typedef enum logic [2:0] {
        CYC_IDLE    = 3'd0,
        CYC_OPEN_RD = 3'd1,
        CYC_CLAIMED = 3'd2,
        CYC_WRITE   = 3'd3,
        CYC_ACK     = 3'd4
    } cyc_e;
endpackage

// File: rtl/fbus_attr_latch.sv
module fbus_attr_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] attr_byte,
    input  logic         attr_stb,
    output logic [W-1:0] attr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        attr_q <= '1;
        else if (attr_stb) attr_q <= attr_byte;
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        attr_stb |=> attr_q == $past(attr_byte));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !attr_stb |=> $stable(attr_q));
endmodule

// File: rtl/fbus_cycle_fsm.sv
module fbus_cycle_fsm
    import fbus_pkg::*;
#(
    parameter int N_PORTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               iorq_n,
    input  logic               rd_n,
    input  logic               m1_n,
    input  logic [N_PORTS-1:0] port_hit,
    output cyc_e               state,
    output logic               open_rd
);
    cyc_e state_nx;
    logic any_hit;

    assign any_hit = |port_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CYC_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (iorq_n) begin
            state_nx = CYC_IDLE;
        end else begin
            unique case (state)
                CYC_IDLE, CYC_OPEN_RD: begin
                    if (!m1_n)       state_nx = CYC_ACK;
                    else if (any_hit) state_nx = CYC_CLAIMED;
                    else if (!rd_n)  state_nx = CYC_OPEN_RD;
                    else             state_nx = CYC_WRITE;
                end
                CYC_CLAIMED: state_nx = CYC_CLAIMED;
                CYC_WRITE:   state_nx = CYC_WRITE;
                CYC_ACK:     state_nx = CYC_ACK;
                default:     state_nx = CYC_IDLE;
            endcase
        end
    end

    always_comb begin
        open_rd = (state == CYC_OPEN_RD);
    end

    p_release_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iorq_n |=> state == CYC_IDLE);
    p_ack_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && !m1_n) |=> state != CYC_OPEN_RD);
    p_ack_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_ACK && !iorq_n) |=> state == CYC_ACK);
    p_claim_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && any_hit) |=> !open_rd);
    p_write_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && rd_n) |=> state != CYC_OPEN_RD);
endmodule

// File: rtl/fbus_drive_mux.sv
module fbus_drive_mux #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open_rd,
    input  logic         attr_window,
    input  logic [W-1:0] attr_q,
    output logic         bus_drive,
    output logic [W-1:0] bus_data,
    output logic [W-1:0] bus_view
);
    assign bus_drive = open_rd & attr_window;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bus_data[i] = bus_drive ? attr_q[i] : 1'b1;
        assign bus_view[i] = bus_drive ? bus_data[i] : 1'b1;
    end

    p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> attr_window);
    p_idle_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drive |-> (bus_view == '1 && bus_data == '1));
    p_drive_val_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> bus_view == attr_q);
endmodule

// File: rtl/fbus_attr_port.sv
module fbus_attr_port
    import fbus_pkg::*;
#(
    parameter int W       = 8,
    parameter int N_PORTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       attr_byte,
    input  logic               attr_stb,
    input  logic               attr_window,
    input  logic               iorq_n,
    input  logic               rd_n,
    input  logic               m1_n,
    input  logic [N_PORTS-1:0] port_hit,
    output logic               bus_drive,
    output logic [W-1:0]       bus_data,
    output logic [W-1:0]       bus_view
);
    logic [W-1:0] attr_q;
    cyc_e         state;
    logic         open_rd;

    fbus_attr_latch #(.W(W)) u_latch (
        .clk(clk), .rst_n(rst_n), .attr_byte(attr_byte),
        .attr_stb(attr_stb), .attr_q(attr_q)
    );

    fbus_cycle_fsm #(.N_PORTS(N_PORTS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .m1_n(m1_n), .port_hit(port_hit), .state(state), .open_rd(open_rd)
    );

    fbus_drive_mux #(.W(W)) u_mux (
        .clk(clk), .rst_n(rst_n), .open_rd(open_rd),
        .attr_window(attr_window), .attr_q(attr_q),
        .bus_drive(bus_drive), .bus_data(bus_data), .bus_view(bus_view)
    );

    p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> !bus_drive);
endmodule

// File: tb/fbus_attr_port_tb.sv
module fbus_attr_port_tb;
    localparam int NP = 4;
    localparam int LINE = 24;
    localparam int WIN_LO = 4;
    localparam int WIN_HI = 20;
    localparam int S_IDLE = 0, S_OPEN = 1, S_CLAIM = 2, S_WR = 3, S_ACK = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    attr_byte = 8'h00;
    logic          attr_stb = 1'b0;
    logic          attr_window = 1'b0;
    logic          iorq_n = 1'b1, rd_n = 1'b1, m1_n = 1'b1;
    logic [NP-1:0] port_hit = '0;
    logic          bus_drive;
    logic [7:0]    bus_data, bus_view;

    int   n_chk = 0, n_fail = 0;
    int   m_st = S_IDLE;
    logic [7:0] m_attr = 8'hFF;
    bit   rast_en = 1'b0;
    int   pos = 0;

    always #4 clk = ~clk;

    fbus_attr_port #(.W(8), .N_PORTS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .attr_byte(attr_byte), .attr_stb(attr_stb),
        .attr_window(attr_window), .iorq_n(iorq_n), .rd_n(rd_n), .m1_n(m1_n),
        .port_hit(port_hit), .bus_drive(bus_drive), .bus_data(bus_data),
        .bus_view(bus_view)
    );

    function automatic int next_st(int cur, logic iq, logic rd, logic m1, logic hit);
        if (iq) return S_IDLE;
        if (cur == S_CLAIM || cur == S_WR || cur == S_ACK) return cur;
        if (!m1) return S_ACK;
        if (hit) return S_CLAIM;
        if (!rd) return S_OPEN;
        return S_WR;
    endfunction

    function automatic string tag_of(int st, logic win);
        case (st)
            S_OPEN:  return win ? "R3" : "R4";
            S_CLAIM: return "R6";
            S_WR:    return "R7";
            S_ACK:   return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model and per-cycle checks
    always @(posedge clk) begin
        logic edrv;
        logic [7:0] eview;
        if (!rst_n) begin
            m_st = S_IDLE;
            m_attr = 8'hFF;
        end else begin
            if (attr_stb) m_attr = attr_byte;
            m_st = next_st(m_st, iorq_n, rd_n, m1_n, |port_hit);
        end
        #2;
        if (!rst_n) begin
            check("R1", {31'd0, bus_drive}, 32'd0);
            check("R1", {24'd0, bus_view}, 32'hFF);
        end else begin
            edrv = (m_st == S_OPEN) && attr_window;
            eview = edrv ? m_attr : 8'hFF;
            check(tag_of(m_st, attr_window), {31'd0, bus_drive}, {31'd0, edrv});
            check(tag_of(m_st, attr_window), {24'd0, bus_view}, {24'd0, eview});
            if (!bus_drive) check("R8", {24'd0, bus_data}, 32'hFF);
        end
    end

    task automatic step();
        @(negedge clk);
        if (rast_en) begin
            attr_window = (pos >= WIN_LO) && (pos < WIN_HI);
            attr_stb = attr_window && (pos % 2 == 0);
            attr_byte = 8'($urandom);
            pos = (pos + 1) % LINE;
        end
    endtask

    task automatic bus(logic iq, logic rd, logic m1, logic [NP-1:0] hit);
        iorq_n = iq; rd_n = rd; m1_n = m1; port_hit = hit;
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) step();
        rst_n = 1'b1;
        // R1: first cycle after reset, and latch reset value seen through an open read
        step();
        attr_window = 1'b1;
        bus(1'b0, 1'b0, 1'b1, '0);
        @(posedge clk); #3;
        check("R1", {24'd0, bus_view}, 32'hFF);
        step(); bus(1'b1, 1'b1, 1'b1, '0);
        // R2: load then hold
        step(); attr_byte = 8'h5A; attr_stb = 1'b1;
        step(); attr_stb = 1'b0; attr_byte = 8'h11;
        bus(1'b0, 1'b0, 1'b1, '0);
        @(posedge clk); #3;
        check("R2", {24'd0, bus_view}, 32'h5A);
        // R4: window closes mid-read
        step(); attr_window = 1'b0;
        #1 check("R4", {24'd0, bus_view}, 32'hFF);
        step(); attr_window = 1'b1; bus(1'b1, 1'b1, 1'b1, '0);
        // R5: acknowledge, then M1 rises while request stays low
        step(); bus(1'b0, 1'b1, 1'b0, '0);
        step(); bus(1'b0, 1'b0, 1'b1, '0);
        @(posedge clk); #3;
        check("R5", {31'd0, bus_drive}, 32'd0);
        step(); bus(1'b1, 1'b1, 1'b1, '0);
        // R6: claimed access, hit drops mid-cycle
        step(); bus(1'b0, 1'b0, 1'b1, 4'b0100);
        step(); bus(1'b0, 1'b0, 1'b1, '0);
        @(posedge clk); #3;
        check("R6", {24'd0, bus_view}, 32'hFF);
        step(); bus(1'b1, 1'b1, 1'b1, '0);
        // R7: write then read strobe falls
        step(); bus(1'b0, 1'b1, 1'b1, '0);
        step(); bus(1'b0, 1'b0, 1'b1, '0);
        @(posedge clk); #3;
        check("R7", {31'd0, bus_drive}, 32'd0);
        step(); bus(1'b1, 1'b1, 1'b1, '0);
        @(posedge clk); #3;
        check("R9", {31'd0, bus_drive}, 32'd0);
        // random bus cycles against a running raster
        rast_en = 1'b1;
        begin
            int hold = 0;
            for (int i = 0; i < 4000; i++) begin
                step();
                if (hold == 0) begin
                    if (!iorq_n) begin
                        bus(1'b1, 1'b1, 1'b1, '0);
                        hold = 1 + int'($urandom_range(1));
                    end else begin
                        case ($urandom_range(3))
                            0: bus(1'b0, 1'b0, 1'b1, '0);
                            1: bus(1'b0, 1'b1, 1'b1, '0);
                            2: bus(1'b0, 1'b1, 1'b0, '0);
                            default: bus(1'b0, 1'b0, 1'b1, NP'(1) << $urandom_range(NP-1));
                        endcase
                        hold = 2 + int'($urandom_range(3));
                    end
                end else if (!iorq_n && $urandom_range(7) == 0) begin
                    m1_n = ~m1_n;
                    port_hit = '0;
                end
                hold--;
            end
        end
        step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule